// File: doc/BRIEF.md
# Serial 16-bit Control and Status Register Interface

This block is a serial slave that lets a host controller read and write a small bank of control and status registers over a four-wire serial link: clock, active-low chip select, data in and data out. Every exchange is one 16-bit frame. The first three bits of the frame name a register, the fourth tells whether the frame may modify it, and the remaining twelve carry data. While the host shifts a frame in, the block shifts back the contents of the addressed register, so any frame doubles as a read.

The serial inputs are oversampled by the block's own clock through a two-stage synchronizer, so the whole block, including the register bank, runs in a single clock domain. Four registers are implemented: a watchdog configuration register that also reflects live status inputs, an operating mode register, an interrupt/wake configuration register, and an interrupt status register whose bits are latched by event inputs and cleared by writing ones. The configuration fields drive output ports consumed by the rest of the chip.

Top module: `sbc_spi_regif`

## Requirements
- R1: A frame is 16 bits, most significant bit first, sampled on the rising edge of SCK. Bits 15:13 hold the register address, bit 12 the protect flag, bits 11:0 the data. SCK, chip select and SDI are resynchronized, so a change on them takes effect at the third clock rising edge after it.
- R2: The data output enable is high only while chip select is low. The reply has bits 15:12 at zero and bits 11:0 equal to the addressed register as it stood when the fourth frame bit was sampled; the first reply bit appears when chip select falls and each later one after a falling SCK edge.
- R3: A write takes effect only at the rising edge of chip select and only when exactly 16 rising SCK edges were seen in the frame; a frame of 15 or 17 bits changes nothing.
- R4: A frame with bit 12 set reads the addressed register and leaves every register unchanged.
- R5: Address 0: bit 11 watchdog mode (reset 0), bits 10:8 watchdog period code (reset 100), bits 7:3 read the live status input, bits 2:0 read as zero.
- R6: Address 1: bits 11:10 operating mode (reset 00), bit 9 hold flag (reset 1), bits 8:0 read as zero and ignore writes.
- R7: Address 2: bits 11:8 interrupt enables, bits 7:6 wake input A configuration, bits 5:4 wake input B configuration, all reset to zero; bits 3:0 read as zero.
- R8: Address 3: bits 11:4 are event latches, bit 4+i set when event input i is high; writing 1 to a latch clears it, writing 0 leaves it; bits 3:0 read as zero. A latch never clears without such a write.
- R9: When an event input is high in the same cycle that a write clears its latch, the latch stays set.
- R10: Addresses 4 to 7 read as zero and a write to them changes no register.
- R11: After reset all configuration outputs hold their reset values and the output enable is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock, oversamples the serial link |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sck_i | input | 1 | Serial clock from host |
| csn_i | input | 1 | Active-low chip select |
| sdi_i | input | 1 | Serial data from host |
| stat_i | input | 5 | Live status bits shown in address 0 |
| evt_i | input | 8 | Event inputs latched in address 3 |
| sdo_o | output | 1 | Serial data to host |
| sdo_oe_o | output | 1 | Output enable for sdo_o |
| wd_mode_o | output | 1 | Watchdog mode field |
| wd_period_o | output | 3 | Watchdog period code |
| op_mode_o | output | 2 | Operating mode field |
| hold_flag_o | output | 1 | Hold flag |
| irq_en_o | output | 4 | Interrupt enables |
| wake_a_cfg_o | output | 2 | Wake input A configuration |
| wake_b_cfg_o | output | 2 | Wake input B configuration |

## Verification
The bench aims at frame-length errors: a 15-bit frame and a 17-bit frame whose last 16 bits form a valid write must both leave the registers alone, which a design that commits on any chip select rise, or that counts modulo 16, would violate. It checks that a protected frame does not write and that writes to unused addresses do not alias onto a real register, which a design decoding only two address bits would get wrong. It pulses an event input in exactly the cycle a clear is committed; a design that lets the clear win drops the latch. Replies are checked on write frames too, so a design that returns the new value instead of the old, or leaks written values into reserved bits, shows a wrong reply.

// File: rtl/sbc_spi_pkg.sv
package sbc_spi_pkg;
  localparam int FRAME_W  = 16;
  localparam int ADDR_W   = 3;
  localparam int DATA_W   = 12;
  localparam int HDR_BITS = ADDR_W + 1;
  localparam int STAT_W   = 5;
  localparam int EVT_W    = 8;
  localparam int EVT_LSB  = DATA_W - EVT_W;
  localparam int CNT_W    = $clog2(FRAME_W + 2);
  localparam int SYNC_STG = 2;

  typedef enum logic [ADDR_W-1:0] {
    A_WDOG  = 3'd0,
    A_MODE  = 3'd1,
    A_ICTL  = 3'd2,
    A_ISTAT = 3'd3
  } reg_addr_e;

  typedef struct packed {
    logic       wd_mode;
    logic [2:0] wd_period;
    logic [1:0] op_mode;
    logic       hold_flag;
    logic [3:0] irq_en;
    logic [1:0] wake_a;
    logic [1:0] wake_b;
  } ctrl_t;

  localparam ctrl_t CTRL_RST = '{wd_mode: 1'b0, wd_period: 3'b100, op_mode: 2'b00,
                                 hold_flag: 1'b1, irq_en: 4'h0, wake_a: 2'b00,
                                 wake_b: 2'b00};
endpackage

// File: rtl/sbc_spi_sync.sv
module sbc_spi_sync #(
  parameter int           W       = 3,
  parameter int           STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stg
    if (g == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stg[g] <= RST_VAL;
        else         stg[g] <= d_i;
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stg[g] <= RST_VAL;
        else         stg[g] <= stg[g-1];
    end
  end

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/sbc_spi_frame.sv
module sbc_spi_frame
  import sbc_spi_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              csn_s_i,
  input  logic              sck_s_i,
  input  logic              sdi_s_i,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic [ADDR_W-1:0] rd_addr_o,
  output logic              sdo_o,
  output logic              sdo_oe_o,
  output logic              wr_en_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [DATA_W-1:0] wr_data_o
);
  logic               csn_d, sck_d, sdo_q;
  logic [FRAME_W-1:0] shift_q;
  logic [DATA_W-1:0]  tx_q;
  logic [CNT_W-1:0]   cnt_q;
  logic               cs_fall, cs_rise, sck_rise, sck_fall, hdr_done;

  assign cs_fall  = csn_d & ~csn_s_i;
  assign cs_rise  = ~csn_d & csn_s_i;
  assign sck_rise = ~csn_s_i & sck_s_i & ~sck_d;
  assign sck_fall = ~csn_s_i & ~sck_s_i & sck_d;
  assign hdr_done = sck_rise && (cnt_q == CNT_W'(HDR_BITS - 1));

  // header so far: address bits already sit in the low end of the shifter
  assign rd_addr_o = shift_q[ADDR_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      csn_d   <= 1'b1;
      sck_d   <= 1'b0;
      shift_q <= '0;
      tx_q    <= '0;
      cnt_q   <= '0;
      sdo_q   <= 1'b0;
    end else begin
      csn_d <= csn_s_i;
      sck_d <= sck_s_i;
      if (cs_fall) begin
        cnt_q   <= '0;
        shift_q <= '0;
        tx_q    <= '0;
        sdo_q   <= 1'b0;
      end else if (sck_rise) begin
        shift_q <= {shift_q[FRAME_W-2:0], sdi_s_i};
        if (cnt_q != CNT_W'(FRAME_W + 1)) cnt_q <= cnt_q + 1'b1;
        if (hdr_done) tx_q <= rd_data_i;
      end else if (sck_fall) begin
        if (cnt_q >= CNT_W'(HDR_BITS)) begin
          sdo_q <= tx_q[DATA_W-1];
          tx_q  <= {tx_q[DATA_W-2:0], 1'b0};
        end else begin
          sdo_q <= 1'b0;
        end
      end
    end
  end

  assign sdo_o     = sdo_q;
  assign sdo_oe_o  = ~csn_s_i;
  assign wr_en_o   = cs_rise && (cnt_q == CNT_W'(FRAME_W)) && !shift_q[DATA_W];
  assign wr_addr_o = shift_q[FRAME_W-1 -: ADDR_W];
  assign wr_data_o = shift_q[DATA_W-1:0];
endmodule

// File: rtl/sbc_spi_regbank.sv
module sbc_spi_regbank
  import sbc_spi_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  input  logic [STAT_W-1:0] stat_i,
  input  logic [EVT_W-1:0]  evt_i,
  output logic [DATA_W-1:0] rd_data_o,
  output ctrl_t             ctrl_o,
  output logic [EVT_W-1:0]  ist_o
);
  ctrl_t            ctrl_q;
  logic [EVT_W-1:0] ist_q, clr;

  assign clr = (wr_en_i && wr_addr_i == A_ISTAT) ? wr_data_i[DATA_W-1:EVT_LSB] : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= CTRL_RST;
      ist_q  <= '0;
    end else begin
      ist_q <= (ist_q & ~clr) | evt_i;  // a new event beats a clear
      if (wr_en_i) begin
        case (wr_addr_i)
          A_WDOG: begin
            ctrl_q.wd_mode   <= wr_data_i[11];
            ctrl_q.wd_period <= wr_data_i[10:8];
          end
          A_MODE: begin
            ctrl_q.op_mode   <= wr_data_i[11:10];
            ctrl_q.hold_flag <= wr_data_i[9];
          end
          A_ICTL: begin
            ctrl_q.irq_en <= wr_data_i[11:8];
            ctrl_q.wake_a <= wr_data_i[7:6];
            ctrl_q.wake_b <= wr_data_i[5:4];
          end
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (rd_addr_i)
      A_WDOG:  rd_data_o = {ctrl_q.wd_mode, ctrl_q.wd_period, stat_i, 3'b000};
      A_MODE:  rd_data_o = {ctrl_q.op_mode, ctrl_q.hold_flag, 9'd0};
      A_ICTL:  rd_data_o = {ctrl_q.irq_en, ctrl_q.wake_a, ctrl_q.wake_b, 4'h0};
      A_ISTAT: rd_data_o = {ist_q, {EVT_LSB{1'b0}}};
      default: rd_data_o = '0;
    endcase
  end

  assign ctrl_o = ctrl_q;
  assign ist_o  = ist_q;
endmodule

// File: rtl/sbc_spi_regif.sv
module sbc_spi_regif
  import sbc_spi_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sck_i,
  input  logic              csn_i,
  input  logic              sdi_i,
  input  logic [STAT_W-1:0] stat_i,
  input  logic [EVT_W-1:0]  evt_i,
  output logic              sdo_o,
  output logic              sdo_oe_o,
  output logic              wd_mode_o,
  output logic [2:0]        wd_period_o,
  output logic [1:0]        op_mode_o,
  output logic              hold_flag_o,
  output logic [3:0]        irq_en_o,
  output logic [1:0]        wake_a_cfg_o,
  output logic [1:0]        wake_b_cfg_o
);
  logic              csn_s, sck_s, sdi_s, wr_en;
  logic [ADDR_W-1:0] wr_addr, rd_addr;
  logic [DATA_W-1:0] wr_data, rd_data;
  logic [EVT_W-1:0]  int_stat;
  ctrl_t             ctrl;

  sbc_spi_sync #(.W(3), .STAGES(SYNC_STG), .RST_VAL(3'b100)) u_sync (
    .clk_i, .rst_ni,
    .d_i({csn_i, sck_i, sdi_i}),
    .q_o({csn_s, sck_s, sdi_s})
  );

  sbc_spi_frame u_frame (
    .clk_i, .rst_ni,
    .csn_s_i(csn_s), .sck_s_i(sck_s), .sdi_s_i(sdi_s),
    .rd_data_i(rd_data), .rd_addr_o(rd_addr),
    .sdo_o, .sdo_oe_o,
    .wr_en_o(wr_en), .wr_addr_o(wr_addr), .wr_data_o(wr_data)
  );

  sbc_spi_regbank u_regs (
    .clk_i, .rst_ni,
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .rd_addr_i(rd_addr), .stat_i, .evt_i,
    .rd_data_o(rd_data), .ctrl_o(ctrl), .ist_o(int_stat)
  );

  assign wd_mode_o    = ctrl.wd_mode;
  assign wd_period_o  = ctrl.wd_period;
  assign op_mode_o    = ctrl.op_mode;
  assign hold_flag_o  = ctrl.hold_flag;
  assign irq_en_o     = ctrl.irq_en;
  assign wake_a_cfg_o = ctrl.wake_a;
  assign wake_b_cfg_o = ctrl.wake_b;
endmodule

// File: rtl/sbc_spi_regif_chk.sv
module sbc_spi_regif_chk
  import sbc_spi_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             csn_i,
  input logic             sdo_oe_o,
  input logic             wr_en,
  input logic [EVT_W-1:0] evt_i,
  input logic [EVT_W-1:0] int_stat,
  input ctrl_t            ctrl
);
  // R2: output enable stays low once chip select has been high long enough
  p_oe_idle_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(csn_i, 2) |-> !sdo_oe_o);

  // R3: a commit only happens after chip select went high
  p_commit_cs_high_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en |-> $past(csn_i, 2));

  // R3: configuration only moves on a commit
  p_ctrl_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en |=> $stable(ctrl));

  // R8: latches never drop without a write
  p_no_silent_clear_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en |=> ((~int_stat & $past(int_stat)) == '0));

  // R9: a present event always leaves its latch set
  p_event_wins_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|evt_i) |=> ((int_stat & $past(evt_i)) == $past(evt_i)));
endmodule

bind sbc_spi_regif sbc_spi_regif_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .csn_i(csn_i), .sdo_oe_o(sdo_oe_o),
  .wr_en(wr_en), .evt_i(evt_i), .int_stat(int_stat), .ctrl(ctrl)
);

// File: tb/sbc_spi_regif_tb.sv
`timescale 1ns/1ps
module sbc_spi_regif_tb;
  localparam int HALF = 8;

  logic clk = 0, rst_ni = 0;
  logic sck = 0, csn = 1, sdi = 0;
  logic [4:0] stat = 5'b10110;
  logic [7:0] evt = '0;
  logic sdo, sdo_oe, wd_mode, hold_flag;
  logic [2:0] wd_period;
  logic [1:0] op_mode, wake_a, wake_b;
  logic [3:0] irq_en;

  int n_run = 0, n_fail = 0;
  bit chk_en = 0;

  // reference state
  logic       m_wdm = 0, m_flag = 1;
  logic [2:0] m_per = 3'b100;
  logic [1:0] m_mode = 0, m_wa = 0, m_wb = 0;
  logic [3:0] m_irq = 0;
  logic [7:0] m_ist = 0;

  always #2 clk = ~clk;

  sbc_spi_regif u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .sck_i(sck), .csn_i(csn), .sdi_i(sdi),
    .stat_i(stat), .evt_i(evt), .sdo_o(sdo), .sdo_oe_o(sdo_oe),
    .wd_mode_o(wd_mode), .wd_period_o(wd_period), .op_mode_o(op_mode),
    .hold_flag_o(hold_flag), .irq_en_o(irq_en), .wake_a_cfg_o(wake_a),
    .wake_b_cfg_o(wake_b)
  );

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string req);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [17:0] m_ctrl();
    return {m_wdm, m_per, m_mode, m_flag, m_irq, m_wa, m_wb};
  endfunction

  function automatic logic [11:0] m_read(input logic [2:0] a);
    case (a)
      3'd0: return {m_wdm, m_per, stat, 3'b000};
      3'd1: return {m_mode, m_flag, 9'd0};
      3'd2: return {m_irq, m_wa, m_wb, 4'h0};
      3'd3: return {m_ist, 4'h0};
      default: return 12'h000;
    endcase
  endfunction

  // R11 / R3: outputs match the reference whenever the link is idle
  always @(negedge clk)
    if (chk_en)
      check({14'd0, wd_mode, wd_period, op_mode, hold_flag, irq_en, wake_a, wake_b, sdo_oe},
            {14'd0, m_ctrl(), 1'b0}, "R3/R11 idle outputs");

  task automatic xfer(input logic [31:0] w, input int nb, input logic [7:0] evt_end,
                      output logic [31:0] rx);
    rx = '0;
    @(negedge clk); chk_en = 0; csn = 0;
    repeat (HALF) @(negedge clk);
    check({31'd0, sdo_oe}, 32'd1, "R2 oe during frame");
    for (int i = nb - 1; i >= 0; i--) begin
      sdi = w[i];
      repeat (HALF) @(negedge clk);
      rx = {rx[30:0], sdo};
      sck = 1;
      repeat (HALF) @(negedge clk);
      sck = 0;
    end
    repeat (HALF) @(negedge clk);
    csn = 1;
    // R1: the commit lands on the third clock edge after chip select rises
    @(posedge clk); @(posedge clk); @(negedge clk);
    evt = evt_end;
    @(negedge clk);
    evt = '0;
    repeat (HALF) @(negedge clk);
  endtask

  task automatic frame(input logic [2:0] a, input logic ro, input logic [11:0] d,
                       input logic [7:0] evt_end, input string req);
    logic [31:0] rx;
    logic [11:0] exp_rd;
    exp_rd = m_read(a);
    xfer({16'd0, a, ro, d}, 16, evt_end, rx);
    check(rx, {20'd0, exp_rd}, req);
    if (!ro) begin
      case (a)
        3'd0: begin m_wdm = d[11]; m_per = d[10:8]; end
        3'd1: begin m_mode = d[11:10]; m_flag = d[9]; end
        3'd2: begin m_irq = d[11:8]; m_wa = d[7:6]; m_wb = d[5:4]; end
        3'd3: m_ist = m_ist & ~d[11:4];
        default: ;
      endcase
    end
    m_ist = m_ist | evt_end;
    chk_en = 1;
  endtask

  task automatic pulse_evt(input logic [7:0] m);
    @(negedge clk); evt = m;
    @(negedge clk); evt = '0;
    m_ist = m_ist | m;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] rx;
    repeat (4) @(negedge clk);
    rst_ni = 1;
    repeat (4) @(negedge clk);
    // R11: reset values
    check({14'd0, wd_mode, wd_period, op_mode, hold_flag, irq_en, wake_a, wake_b, sdo_oe},
          {14'd0, 1'b0, 3'b100, 2'b00, 1'b1, 4'h0, 2'b00, 2'b00, 1'b0}, "R11 reset");
    chk_en = 1;

    // R5 R6 R7 R8: read each register with protect flag set
    frame(3'd0, 1, 12'h000, 8'h00, "R5 read wdog");
    frame(3'd1, 1, 12'h000, 8'h00, "R6 read mode");
    frame(3'd2, 1, 12'h000, 8'h00, "R7 read ictl");
    frame(3'd3, 1, 12'h000, 8'h00, "R8 read istat");

    // R5: write, reply is old value; reserved bits stay zero
    frame(3'd0, 0, 12'hBFF, 8'h00, "R2 reply old wdog");
    frame(3'd0, 1, 12'h000, 8'h00, "R5 wdog readback");
    stat = 5'b01001;
    frame(3'd0, 1, 12'h000, 8'h00, "R5 live status");

    // R6
    frame(3'd1, 0, 12'hFFF, 8'h00, "R6 write ones");
    frame(3'd1, 0, 12'h500, 8'h00, "R6 write 01/0");
    frame(3'd1, 1, 12'h000, 8'h00, "R6 readback");

    // R7
    frame(3'd2, 0, 12'hA5F, 8'h00, "R7 write");
    frame(3'd2, 1, 12'h000, 8'h00, "R7 readback");

    // R4: protected frame carrying data does not write
    frame(3'd2, 1, 12'h3C0, 8'h00, "R4 protected");
    frame(3'd0, 1, 12'h000, 8'h00, "R4 wdog unchanged");

    // R3: 15-bit and 17-bit frames are dropped
    xfer({17'd0, 3'd2, 1'b0, 12'h0F0}, 15, 8'h00, rx);
    chk_en = 1;
    frame(3'd2, 1, 12'h000, 8'h00, "R3 after 15-bit frame");
    xfer({16'd1, 3'd2, 1'b0, 12'h0F0}, 17, 8'h00, rx);
    chk_en = 1;
    frame(3'd2, 1, 12'h000, 8'h00, "R3 after 17-bit frame");

    // R10: unused addresses
    frame(3'd5, 0, 12'hFFF, 8'h00, "R10 write addr5");
    frame(3'd4, 0, 12'h000, 8'h00, "R10 write addr4");
    frame(3'd5, 1, 12'h000, 8'h00, "R10 read addr5");
    frame(3'd0, 1, 12'h000, 8'h00, "R10 wdog intact");
    frame(3'd1, 1, 12'h000, 8'h00, "R10 mode intact");

    // R8: event latch, write-1 clear, write-0 keep
    pulse_evt(8'h3C);
    frame(3'd3, 1, 12'h000, 8'h00, "R8 latched");
    frame(3'd3, 0, 12'h140, 8'h00, "R8 clear mask");
    frame(3'd3, 1, 12'h000, 8'h00, "R8 after clear");
    frame(3'd3, 0, 12'h000, 8'h00, "R8 zero write");
    frame(3'd3, 1, 12'h000, 8'h00, "R8 zero kept");

    // R9: event in the commit cycle wins over the clear
    pulse_evt(8'h81);
    frame(3'd3, 0, 12'hFF0, 8'h81, "R9 clear all");
    frame(3'd3, 1, 12'h000, 8'h00, "R9 event kept");
    frame(3'd3, 0, 12'hFF0, 8'h00, "R9 final clear");
    frame(3'd3, 1, 12'h000, 8'h00, "R9 empty");

    repeat (4) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule